// File: doc/BRIEF.md
# Reference-to-Slow Clock Ratio Meter

This block estimates the frequency of a slow, loosely specified low-power clock by counting how many cycles of a fast, accurate reference clock elapse across four consecutive periods of the slow clock. All of its logic runs on the reference clock. The slow clock enters as an asynchronous signal. It is resynchronised by a flop chain, and its rising edges are detected in the reference domain.

Software controls the block through one 32-bit control/status word at byte offset 0x66C. Bit 31 of this word starts and stops measurement. Bits 12:0 hold the latest measured count and are read-only. Measurement is continuous: each time a four-period window closes, the count field is refreshed, and the next window starts on the same slow edge. Software can poll the field, average the samples itself, and then write zero to the word to stop the counter and save power.

Top module: `ratio_meter`

## Requirements
- R1: After reset, reading offset 0x66C returns all zeros (measurement off, count field 0).
- R2: A write to offset 0x66C sets the enable flag from write-data bit 31, and the flag reads back on bit 31. Writing zero clears the flag and stops measurement.
- R3: While enabled with a slow-clock period of P reference cycles, bits 12:0 read 4*P once a full window has closed.
- R4: A window count larger than 8191 saturates the field at 0x1FFF and does not wrap.
- R5: The field is refreshed at the end of every window, so after the slow period changes from one value to another while enabled, the field later reads four times the new period.
- R6: While disabled, the count field keeps its last value whatever the slow clock does.
- R7: After enable, the field keeps its previous value until a complete four-period window has been measured, starting on a slow rising edge seen after the enable.
- R8: Bits 30:13 of the word always read zero. Reads at any other offset return zero, and writes at any other offset leave the enable flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock; all logic runs on it |
| rst_n | input | 1 | Active-low reset, synchronous to clk_ref |
| slow_clk_async | input | 1 | Slow clock being measured, asynchronous |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |

## Verification
The read path is combinational, so a read is sampled 1 ns after the falling edge at which the address was applied. The enable flag changes on the rising edge after a write strobe, and the bench reads it back one full cycle later. A fresh count appears no earlier than the two synchroniser flops, the edge register and the capture register after the fourth slow edge. For this reason every count check waits for at least two whole windows plus one extra slow period beyond the stimulus. The bench generates the slow clock from the falling edge of the reference, so every period is an exact number of reference cycles and the expected value 4*P, or 8191 when that is exceeded, is exact. A check that the count has not yet been republished is made before any full window can have closed, which is less than 4*P cycles after the enable.

// File: rtl/rm_pkg.sv
package rm_pkg;
   typedef enum logic {
      PH_IDLE  = 1'b0,
      PH_TIMING = 1'b1
   } meter_phase_e;

   localparam int unsigned DEF_RESULT_W = 13;
   localparam int unsigned DEF_WINDOW   = 4;
endpackage

// File: rtl/rm_edge_sync.sv
module rm_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("rm_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~last_q;

   // R3: every detected edge is a single-cycle pulse
   assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);
endmodule

// File: rtl/rm_window_counter.sv
module rm_window_counter
   import rm_pkg::*;
#(
   parameter int unsigned RESULT_W = DEF_RESULT_W,
   parameter int unsigned WINDOW   = DEF_WINDOW,
   parameter bit          SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                enable_i,
   input  logic                edge_i,
   output logic [RESULT_W-1:0] result_o
);
   localparam int unsigned EW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   localparam logic [RESULT_W-1:0] CNT_MAX  = {RESULT_W{1'b1}};
   localparam logic [EW-1:0]       LAST_IDX = EW'(WINDOW - 1);

   generate
      if (WINDOW < 2) begin : g_bad_window
         $error("rm_window_counter: WINDOW must be at least 2");
      end
   endgenerate

   meter_phase_e        phase_q;
   logic [EW-1:0]       seen_q;
   logic [RESULT_W-1:0] cnt_q;
   logic [RESULT_W-1:0] cnt_inc;
   logic [RESULT_W-1:0] result_q;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + RESULT_W'(1);
      end else begin : g_wrap
         assign cnt_inc = cnt_q + RESULT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         seen_q   <= '0;
         cnt_q    <= '0;
         result_q <= '0;
      end else if (!enable_i) begin
         phase_q <= PH_IDLE;
         seen_q  <= '0;
         cnt_q   <= '0;
      end else if (edge_i) begin
         if (phase_q == PH_IDLE) begin
            phase_q <= PH_TIMING;
            seen_q  <= '0;
            cnt_q   <= RESULT_W'(1);
         end else if (seen_q == LAST_IDX) begin
            result_q <= cnt_q;
            seen_q   <= '0;
            cnt_q    <= RESULT_W'(1);
         end else begin
            seen_q <= seen_q + EW'(1);
            cnt_q  <= cnt_inc;
         end
      end else if (phase_q == PH_TIMING) begin
         cnt_q <= cnt_inc;
      end
   end

   assign result_o = result_q;

   // R6: no refresh while measurement is off
   assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> $stable(result_o));

   // R7: disabled state returns to idle with a cleared count
   assert_idle_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |=> (phase_q == PH_IDLE && cnt_q == '0 && seen_q == '0));

   // R5: the result moves only after an edge closed a window
   assert_refresh_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (result_o != $past(result_o)) |-> ($past(edge_i) && $past(enable_i)));

   // R4: a saturated count stays pinned until the window closes
   generate
      if (SATURATE) begin : g_sat_chk
         assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (enable_i && !edge_i && phase_q == PH_TIMING && cnt_q == CNT_MAX)
               |=> (!enable_i || cnt_q == CNT_MAX));
      end
   endgenerate
endmodule

// File: rtl/rm_csr.sv
module rm_csr #(
   parameter int unsigned          ADDR_W   = 12,
   parameter int unsigned          DATA_W   = 32,
   parameter int unsigned          EN_BIT   = 31,
   parameter int unsigned          RESULT_W = 13,
   parameter logic [ADDR_W-1:0]    OFFSET   = 12'h66C
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic [RESULT_W-1:0] result_i,
   output logic                enable_o,
   output logic [DATA_W-1:0]   rdata_o
);
   generate
      if (EN_BIT >= DATA_W || RESULT_W > EN_BIT) begin : g_bad_layout
         $error("rm_csr: enable bit must sit above the result field inside the word");
      end
   endgenerate

   logic hit;
   logic en_q;
   logic unused_wdata;

   assign hit          = (addr_i == OFFSET);
   assign unused_wdata = ^wdata_i;

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= 1'b0;
      else if (wr_i && hit)
         en_q <= wdata_i[EN_BIT];
   end

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         rdata_o[EN_BIT]       = en_q;
         rdata_o[RESULT_W-1:0] = result_i;
      end
   end

   assign enable_o = en_q;

   // R2: enable follows bit 31 of a write to the word
   assert_enable_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && hit) |=> (enable_o == $past(wdata_i[EN_BIT])));

   // R8: other accesses leave enable alone
   assert_enable_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_i && hit) |=> $stable(enable_o));

   // R8: reserved bits never read as one
   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_o[EN_BIT-1:RESULT_W] == '0);
endmodule

// File: rtl/ratio_meter.sv
module ratio_meter #(
   parameter int unsigned       ADDR_W      = 12,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       EN_BIT      = 31,
   parameter int unsigned       RESULT_W    = rm_pkg::DEF_RESULT_W,
   parameter int unsigned       WINDOW      = rm_pkg::DEF_WINDOW,
   parameter int unsigned       SYNC_STAGES = 2,
   parameter bit                SATURATE    = 1'b1,
   parameter logic [ADDR_W-1:0] CSR_OFFSET  = 12'h66C
) (
   input  logic              clk_ref,
   input  logic              rst_n,
   input  logic              slow_clk_async,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   logic                slow_rise;
   logic                meas_en;
   logic [RESULT_W-1:0] ratio;

   rm_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .async_in (slow_clk_async),
      .rise_o   (slow_rise)
   );

   rm_window_counter #(
      .RESULT_W (RESULT_W),
      .WINDOW   (WINDOW),
      .SATURATE (SATURATE)
   ) win_i (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .enable_i (meas_en),
      .edge_i   (slow_rise),
      .result_o (ratio)
   );

   rm_csr #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .EN_BIT   (EN_BIT),
      .RESULT_W (RESULT_W),
      .OFFSET   (CSR_OFFSET)
   ) csr_i (
      .clk      (clk_ref),
      .rst_n    (rst_n),
      .wr_i     (reg_wr),
      .addr_i   (reg_addr),
      .wdata_i  (reg_wdata),
      .result_i (ratio),
      .enable_o (meas_en),
      .rdata_o  (reg_rdata)
   );
endmodule

// File: tb/ratio_meter_tb_top.sv
`timescale 1ns/1ps
module ratio_meter_tb_top;
   localparam logic [11:0] OFS = 12'h66C;

   logic        clk_ref = 1'b0;
   logic        rst_n   = 1'b0;
   logic        slow    = 1'b0;
   logic        reg_wr  = 1'b0;
   logic [11:0] reg_addr  = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_checks = 0;
   int n_fail   = 0;
   int half_p   = 5;
   int ph_cnt   = 0;

   always #2 clk_ref = ~clk_ref;

   always @(negedge clk_ref) begin
      if (ph_cnt >= half_p - 1) begin
         ph_cnt = 0;
         slow <= ~slow;
      end else begin
         ph_cnt = ph_cnt + 1;
      end
   end

   ratio_meter dut_i (
      .clk_ref        (clk_ref),
      .rst_n          (rst_n),
      .slow_clk_async (slow),
      .reg_wr         (reg_wr),
      .reg_addr       (reg_addr),
      .reg_wdata      (reg_wdata),
      .reg_rdata      (reg_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_ref);
   endtask

   task automatic write_word(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk_ref);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk_ref);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   task automatic read_word(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk_ref);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] expect_cnt(input int p);
      int v = 4 * p;
      return (v > 8191) ? 32'h1FFF : 32'(v);
   endfunction

   initial begin : watchdog
      #760000;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : stim
      logic [31:0] rd;
      logic [31:0] held;
      wait_cycles(4);
      rst_n = 1'b1;
      wait_cycles(2);

      read_word(OFS, rd);
      check("R1 reset word", rd, 32'h0);
      read_word(12'h670, rd);
      check("R8 other offset reads zero", rd, 32'h0);

      // R7: no result until a full window after enable
      half_p = 5;
      write_word(OFS, 32'h8000_0000);
      wait_cycles(30);
      read_word(OFS, rd);
      check("R7 no early result", rd, 32'h8000_0000);
      check("R2 enable readback", {31'b0, rd[31]}, 32'h1);
      check("R8 reserved bits zero", {14'b0, rd[30:13]}, 32'h0);
      wait_cycles(16 * 10 + 40);
      read_word(OFS, rd);
      check("R3 first window P=10", rd, 32'h8000_0000 | expect_cnt(10));

      // R3/R5: sweep of periods while enabled
      for (int hp = 2; hp <= 32; hp++) begin
         half_p = hp;
         wait_cycles(16 * (2 * hp) + 40);
         read_word(OFS, rd);
         check($sformatf("R5 R3 period %0d", 2 * hp), rd, 32'h8000_0000 | expect_cnt(2 * hp));
      end

      // R4 boundary: just below the limit, then beyond it
      half_p = 1023;
      wait_cycles(16 * 2046 + 40);
      read_word(OFS, rd);
      check("R4 below limit 8184", rd, 32'h8000_0000 | expect_cnt(2046));
      half_p = 1050;
      wait_cycles(16 * 2100 + 40);
      read_word(OFS, rd);
      check("R4 saturated", rd, 32'h8000_1FFF);

      // R6: disable holds the last count
      half_p = 6;
      wait_cycles(16 * 12 + 40);
      read_word(OFS, rd);
      held = rd & 32'h1FFF;
      check("R3 after saturation P=12", held, expect_cnt(12));
      write_word(OFS, 32'h0);
      half_p = 9;
      wait_cycles(400);
      read_word(OFS, rd);
      check("R2 disable readback", {31'b0, rd[31]}, 32'h0);
      check("R6 count held while off", rd, held);

      // R8: write at another offset ignored
      write_word(12'h668, 32'h8000_0000);
      wait_cycles(200);
      read_word(OFS, rd);
      check("R8 foreign write ignored", rd, held);

      // R7: re-enable measures the new period
      write_word(OFS, 32'h8000_0000);
      wait_cycles(20);
      read_word(OFS, rd);
      check("R7 old value kept after re-enable", rd, 32'h8000_0000 | held);
      wait_cycles(16 * 18 + 40);
      read_word(OFS, rd);
      check("R5 new period P=18", rd, 32'h8000_0000 | expect_cnt(18));

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule